// File: doc/BRIEF.md
# Pseudo-static RAM configuration sequencer

This block owns the asynchronous pins of a pseudo-static RAM while it changes the device's configuration or puts the device to sleep. A one-cycle start pulse with a 2-bit setting launches a chain of six bus cycles. The first two are reads of the all-ones address. The next three are writes to the all-ones address. The last is a write to a code address whose bits 20:19 carry the setting. The value returned by the first read is written back, so the content of the all-ones word survives the sequence. The setting selects how much of the array stays refreshed in standby: 00 keeps a quarter, 01 an eighth, 10 a sixteenth, and 11 selects the deep standby mode.

A separate pair of commands drives the second chip-enable pin low to enter deep power-down, and later releases it. The low pulse is held for a minimum time, and a wake-up delay is enforced after release. The device forgets both its configuration and its contents across a power-down, so the block keeps a shadow copy of the last programmed setting and returns it to the default on wake-up. While the block owns the bus, `busy` is high, and the surrounding memory controller must keep its own traffic off the pins.

States: `ST_IDLE`, `ST_BUS_ACT` (chip enable low, one strobe active), `ST_BUS_REC` (chip enable high, mode-set hold), `ST_DPD_LOW` (minimum power-down width), `ST_DPD_HOLD` (asleep, waiting for release) and `ST_DPD_WAKE` (wake-up delay). The transitions are:

- start: `ST_IDLE` to `ST_BUS_ACT`.
- pd_enter: `ST_IDLE` to `ST_DPD_LOW`.
- act_done: `ST_BUS_ACT` to `ST_BUS_REC`.
- next_cycle: `ST_BUS_REC` to `ST_BUS_ACT`.
- seq_done: `ST_BUS_REC` to `ST_IDLE`.
- min_met: `ST_DPD_LOW` to `ST_DPD_HOLD`.
- pd_exit: `ST_DPD_HOLD` to `ST_DPD_WAKE`.
- wake_done: `ST_DPD_WAKE` to `ST_IDLE`.

Top module: `psram_cfg_seq`

## Requirements
- R1: After reset, the outputs are `busy`=0, `mem_ce1_n`=1, `mem_ce2`=1, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `cfg_shadow`=DEF_SEL (default 2'b11).
- R2: A start pulse in idle produces exactly six chip-enable-low bus cycles.
  - Cycles 1 and 2 are reads: `mem_oe_n`=0 and `mem_we_n`=1.
  - Cycles 3 to 6 are writes: `mem_we_n`=0 and `mem_oe_n`=1.
  - `mem_oe_n` and `mem_we_n` are never both low.
- R3: Cycles 1 to 5 use the all-ones address 0x7FFFFF. Cycle 6 uses an address with bits 20:19 equal to the latched setting and every other bit one.
- R4: The value on `mem_dq_in` at the last clock of the first read is driven on `mem_dq_out` in all four write cycles. The value returned by the second read is not used. `mem_dq_oe` is high only while a write cycle or its hold is in progress.
- R5: Each chip-enable-low phase lasts exactly CYC_CLKS clocks. Each is followed by at least HOLD_CLKS clocks with `mem_ce1_n` high. `mem_lb_n` and `mem_ub_n` are low throughout every programming bus cycle.
- R6: `busy` rises on the clock edge that samples the start pulse. It stays high for exactly 6*(CYC_CLKS+HOLD_CLKS) clocks. A start pulse while busy has no effect on the bus cycles or on the programmed setting.
- R7: `cfg_shadow` takes the latched setting on the edge where `busy` falls after programming. It does not change at any other time while the block is idle.
- R8: A `pd_enter` pulse in idle drives `mem_ce2` low, with `mem_ce1_n` high, for at least DPD_LOW_CLKS clocks.
  - `pd_exit` during that minimum window is ignored.
  - A start pulse while powered down produces no bus cycle.
- R9: A `pd_exit` pulse after the minimum window raises `mem_ce2` and keeps `busy` high for exactly WAKE_CLKS more clocks. `cfg_shadow` returns to DEF_SEL, and programming works again afterwards.
- R10: When `cfg_start` and `pd_enter` arrive in the same idle clock, programming runs and power-down is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | One-clock request to program the configuration |
| cfg_sel | input | 2 | Refresh-area / standby setting, latched with the start pulse |
| pd_enter | input | 1 | One-clock request to enter deep power-down |
| pd_exit | input | 1 | One-clock request to leave deep power-down |
| busy | output | 1 | Block owns the memory pins |
| cfg_shadow | output | 2 | Setting currently held by the device |
| mem_addr | output | 23 | Memory address |
| mem_ce1_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Power-down control chip enable, low = sleep |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_dq_out | output | 16 | Write data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Read data from the memory |

## Verification
The programming chain is run with each of the four settings. Each run uses a different read-back word, so the code address and the returned shadow prove that the setting reaches bits 20:19 and no other bit. The memory model returns one word on the first read and its complement on the second, which shows that write-back uses only the first read. A second start pulse fired mid-sequence, another start pulse sent during power-down, and an early release pulse show that commands arriving in the wrong state leave both the bus and the shadow untouched. The power-down run measures the low width and the wake-up delay, and then checks that the shadow has returned to the default. The last run fires start and power-down entry in the same clock to show which one wins.

// File: rtl/psram_cfg_pkg.sv
package psram_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUS_ACT,
        ST_BUS_REC,
        ST_DPD_LOW,
        ST_DPD_HOLD,
        ST_DPD_WAKE
    } seq_state_t;

    localparam int N_BUS_CYC = 6;
    localparam int N_RD_CYC  = 2;
    localparam int LAST_IDX  = N_BUS_CYC - 1;
    localparam int IDX_W     = $clog2(N_BUS_CYC);

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_cfg_timer.sv
module psram_cfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/psram_cfg_addrgen.sv
module psram_cfg_addrgen
    import psram_cfg_pkg::*;
#(
    parameter int ADDR_W  = 23,
    parameter int SEL_LSB = 19
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        sel,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;
    localparam logic [ADDR_W-1:0] SEL_MASK = ADDR_W'(2'b11) << SEL_LSB;

    logic [ADDR_W-1:0] code_addr;

    always_comb begin
        code_addr = (ALL_ONES & ~SEL_MASK) | (ADDR_W'(sel) << SEL_LSB);
        addr      = (idx == IDX_W'(LAST_IDX)) ? code_addr : ALL_ONES;
    end
endmodule

// File: rtl/psram_cfg_fsm.sv
module psram_cfg_fsm
    import psram_cfg_pkg::*;
#(
    parameter int          ADDR_W       = 23,
    parameter int          DATA_W       = 16,
    parameter int          CYC_CLKS     = 18,
    parameter int          HOLD_CLKS    = 3,
    parameter int          DPD_LOW_CLKS = 2500,
    parameter int          WAKE_CLKS    = 75000,
    parameter logic [1:0]  DEF_SEL      = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_sel,
    input  logic              pd_enter,
    input  logic              pd_exit,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [IDX_W-1:0]  idx,
    output logic [1:0]        sel_lat,
    output logic              busy,
    output logic [1:0]        cfg_shadow,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    localparam int MAX_LEN = max2(max2(CYC_CLKS, HOLD_CLKS), max2(DPD_LOW_CLKS, WAKE_CLKS));
    localparam int TW      = $clog2(MAX_LEN + 1);
    localparam logic [TW-1:0] LD_CYC  = TW'(CYC_CLKS - 1);
    localparam logic [TW-1:0] LD_HOLD = TW'(HOLD_CLKS - 1);
    localparam logic [TW-1:0] LD_DPD  = TW'(DPD_LOW_CLKS - 1);
    localparam logic [TW-1:0] LD_WAKE = TW'(WAKE_CLKS - 1);

    seq_state_t        state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [1:0]        sel_q, shadow_q;
    logic [DATA_W-1:0] cap_q;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              is_read, last_cyc;

    psram_cfg_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign is_read  = (idx_q < IDX_W'(N_RD_CYC));
    assign last_cyc = (idx_q == IDX_W'(LAST_IDX));

    // Next-state and timer load decisions
    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_start) begin              // start (wins over pd_enter)
                    state_d  = ST_BUS_ACT;
                    idx_d    = '0;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CYC;
                end else if (pd_enter) begin      // pd_enter
                    state_d  = ST_DPD_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LD_DPD;
                end
            end
            ST_BUS_ACT: begin
                if (tmr_zero) begin               // act_done
                    state_d  = ST_BUS_REC;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_BUS_REC: begin
                if (tmr_zero) begin
                    if (last_cyc) begin           // seq_done
                        state_d = ST_IDLE;
                    end else begin                // next_cycle
                        state_d  = ST_BUS_ACT;
                        idx_d    = idx_q + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_CYC;
                    end
                end
            end
            ST_DPD_LOW: begin
                if (tmr_zero) state_d = ST_DPD_HOLD;   // min_met
            end
            ST_DPD_HOLD: begin
                if (pd_exit) begin                // pd_exit
                    state_d  = ST_DPD_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_WAKE;
                end
            end
            ST_DPD_WAKE: begin
                if (tmr_zero) state_d = ST_IDLE;  // wake_done
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Setting latch, read capture and shadow copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 2'b00;
            cap_q    <= '0;
            shadow_q <= DEF_SEL;
        end else begin
            if (state_q == ST_IDLE && cfg_start)
                sel_q <= cfg_sel;
            if (state_q == ST_BUS_ACT && idx_q == '0 && tmr_zero)
                cap_q <= mem_dq_in;
            if (state_q == ST_BUS_REC && last_cyc && tmr_zero)
                shadow_q <= sel_q;
            else if (state_q == ST_DPD_HOLD && pd_exit)
                shadow_q <= DEF_SEL;
        end
    end

    // Pin outputs decoded from registered state
    always_comb begin
        busy       = (state_q != ST_IDLE);
        mem_addr   = '0;
        mem_ce1_n  = 1'b1;
        mem_ce2    = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_lb_n   = 1'b1;
        mem_ub_n   = 1'b1;
        mem_dq_out = '0;
        mem_dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DPD_WAKE: ;
            ST_BUS_ACT: begin
                mem_addr   = cyc_addr;
                mem_ce1_n  = 1'b0;
                mem_oe_n   = !is_read;
                mem_we_n   = is_read;
                mem_lb_n   = 1'b0;
                mem_ub_n   = 1'b0;
                mem_dq_out = cap_q;
                mem_dq_oe  = !is_read;
            end
            ST_BUS_REC: begin
                mem_addr   = cyc_addr;
                mem_lb_n   = 1'b0;
                mem_ub_n   = 1'b0;
                mem_dq_out = cap_q;
                mem_dq_oe  = !is_read;
            end
            ST_DPD_LOW, ST_DPD_HOLD: mem_ce2 = 1'b0;
            default: ;
        endcase
    end

    assign idx        = idx_q;
    assign sel_lat    = sel_q;
    assign cfg_shadow = shadow_q;
endmodule

// File: rtl/psram_cfg_seq.sv
module psram_cfg_seq
    import psram_cfg_pkg::*;
#(
    parameter int          ADDR_W       = 23,
    parameter int          DATA_W       = 16,
    parameter int          SEL_LSB      = 19,
    parameter int          CYC_CLKS     = 18,
    parameter int          HOLD_CLKS    = 3,
    parameter int          DPD_LOW_CLKS = 2500,
    parameter int          WAKE_CLKS    = 75000,
    parameter logic [1:0]  DEF_SEL      = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_sel,
    input  logic              pd_enter,
    input  logic              pd_exit,
    output logic              busy,
    output logic [1:0]        cfg_shadow,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    logic [IDX_W-1:0]  idx;
    logic [1:0]        sel_lat;
    logic [ADDR_W-1:0] cyc_addr;

    psram_cfg_addrgen #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)) u_addrgen (
        .idx  (idx),
        .sel  (sel_lat),
        .addr (cyc_addr)
    );

    psram_cfg_fsm #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .CYC_CLKS     (CYC_CLKS),
        .HOLD_CLKS    (HOLD_CLKS),
        .DPD_LOW_CLKS (DPD_LOW_CLKS),
        .WAKE_CLKS    (WAKE_CLKS),
        .DEF_SEL      (DEF_SEL)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_start  (cfg_start),
        .cfg_sel    (cfg_sel),
        .pd_enter   (pd_enter),
        .pd_exit    (pd_exit),
        .cyc_addr   (cyc_addr),
        .mem_dq_in  (mem_dq_in),
        .idx        (idx),
        .sel_lat    (sel_lat),
        .busy       (busy),
        .cfg_shadow (cfg_shadow),
        .mem_addr   (mem_addr),
        .mem_ce1_n  (mem_ce1_n),
        .mem_ce2    (mem_ce2),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_lb_n   (mem_lb_n),
        .mem_ub_n   (mem_ub_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );
endmodule

// File: rtl/psram_cfg_seq_chk.sv
module psram_cfg_seq_chk #(
    parameter int CYC_CLKS = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] cfg_shadow,
    input logic       mem_ce1_n,
    input logic       mem_ce2,
    input logic       mem_oe_n,
    input logic       mem_we_n,
    input logic       mem_lb_n,
    input logic       mem_ub_n,
    input logic       mem_dq_oe
);
    int low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_cnt <= 0;
        else        low_cnt <= mem_ce1_n ? 0 : low_cnt + 1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n)); // R2
    AST_DRIVE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R4
    AST_CE1_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce1_n) |-> (low_cnt == CYC_CLKS)); // R5
    AST_BYTES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_ce2 && !mem_ce1_n) |-> (!mem_lb_n && !mem_ub_n)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce1_n && mem_ce2 && !mem_dq_oe)); // R1
    AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(cfg_shadow)); // R7
    AST_SLEEP_CE1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce2 |-> (mem_ce1_n && busy)); // R8
    AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce2) |-> busy); // R9
endmodule

bind psram_cfg_seq psram_cfg_seq_chk #(.CYC_CLKS(CYC_CLKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cfg_shadow (cfg_shadow),
    .mem_ce1_n  (mem_ce1_n),
    .mem_ce2    (mem_ce2),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/psram_cfg_seq_bench.sv
module psram_cfg_seq_bench;
    localparam int CYC  = 18;
    localparam int HOLD = 3;
    localparam int DPDL = 50;
    localparam int WAKE = 200;
    localparam logic [22:0] ONES = 23'h7FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic        pd_enter = 1'b0;
    logic        pd_exit = 1'b0;
    logic        busy;
    logic [1:0]  cfg_shadow;
    logic [22:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] mem_pat = 16'h0;

    always #2 clk = ~clk;

    psram_cfg_seq #(.CYC_CLKS(CYC), .HOLD_CLKS(HOLD), .DPD_LOW_CLKS(DPDL),
                    .WAKE_CLKS(WAKE), .DEF_SEL(2'b11)) u_psram_cfg_seq (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
        .pd_enter(pd_enter), .pd_exit(pd_exit), .busy(busy), .cfg_shadow(cfg_shadow),
        .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in));

    // Bus monitor: records every chip-enable-low cycle
    int          ncyc, lo_w, gap, min_gap, busy_cnt;
    bit          lb_bad;
    logic [22:0] rec_addr [8];
    logic        rec_rd [8];
    logic        rec_wr [8];
    logic        rec_oe [8];
    logic [15:0] rec_dq [8];
    int          rec_w [8];
    logic [22:0] cur_addr;
    logic        cur_rd, cur_wr, cur_oe;
    logic [15:0] cur_dq;

    // First read returns the pattern, later reads its complement
    assign mem_dq_in = (!mem_ce1_n && !mem_oe_n) ? ((ncyc == 0) ? mem_pat : ~mem_pat) : 16'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (!mem_ce1_n) begin
                if (lo_w == 0 && ncyc > 0 && gap < min_gap) min_gap = gap;
                lo_w++;
                cur_addr = mem_addr;
                cur_rd = !mem_oe_n;
                cur_wr = !mem_we_n;
                cur_oe = mem_dq_oe;
                cur_dq = mem_dq_out;
                if (mem_lb_n || mem_ub_n) lb_bad = 1'b1;
            end else if (lo_w > 0) begin
                if (ncyc < 8) begin
                    rec_addr[ncyc] = cur_addr; rec_rd[ncyc] = cur_rd; rec_wr[ncyc] = cur_wr;
                    rec_oe[ncyc] = cur_oe; rec_dq[ncyc] = cur_dq; rec_w[ncyc] = lo_w;
                end
                ncyc++;
                lo_w = 0;
                gap = 1;
            end else begin
                gap++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        ncyc = 0; lo_w = 0; gap = 0; min_gap = 1000000; busy_cnt = 0; lb_bad = 1'b0;
    endtask

    task automatic pulse_start(input logic [1:0] s);
        @(posedge clk); #1;
        cfg_start = 1'b1; cfg_sel = s;
        @(posedge clk); #1;
        cfg_start = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 100000) begin @(negedge clk); t++; end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic verify_chain(input logic [1:0] s, input logic [15:0] pat, input string tag);
        logic [22:0] code;
        code = (ONES & ~(23'h3 << 19)) | (23'(s) << 19);
        chk(ncyc == 6, "R2", {tag, " cycle count"}, ncyc, 6);
        for (int i = 0; i < 6 && i < ncyc; i++) begin
            chk(rec_rd[i] == (i < 2) && rec_wr[i] == (i >= 2), "R2", {tag, " strobe kind"},
                {rec_rd[i], rec_wr[i]}, (i < 2) ? 2 : 1);
            chk(rec_addr[i] == ((i == 5) ? code : ONES), "R3", {tag, " address"},
                rec_addr[i], (i == 5) ? code : ONES);
            chk(rec_w[i] == CYC, "R5", {tag, " ce1 low width"}, rec_w[i], CYC);
            chk(rec_oe[i] == (i >= 2), "R4", {tag, " dq drive enable"}, rec_oe[i], i >= 2);
            if (i >= 2) chk(rec_dq[i] == pat, "R4", {tag, " write-back data"}, rec_dq[i], pat);
        end
        chk(min_gap >= HOLD, "R5", {tag, " hold gap"}, min_gap, HOLD);
        chk(!lb_bad, "R5", {tag, " byte strobes low"}, lb_bad, 0);
        chk(busy_cnt == 6 * (CYC + HOLD), "R6", {tag, " busy length"}, busy_cnt, 6 * (CYC + HOLD));
        chk(cfg_shadow == s, "R7", {tag, " shadow"}, cfg_shadow, s);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && mem_ce1_n && mem_ce2, "R1", "idle pins", {busy, mem_ce1_n, mem_ce2}, 3'b011);
        chk(mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "strobes", {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b110);
        chk(cfg_shadow == 2'b11, "R1", "shadow default", cfg_shadow, 2'b11);
    endtask

    task automatic t_program(input logic [1:0] s, input logic [15:0] pat);
        clear_mon();
        mem_pat = pat;
        pulse_start(s);
        wait_idle();
        verify_chain(s, pat, "program");
    endtask

    task automatic t_start_while_busy();
        clear_mon();
        mem_pat = 16'h5A0F;
        pulse_start(2'b01);
        repeat (30) @(posedge clk);
        #1 cfg_start = 1'b1; cfg_sel = 2'b10;
        @(posedge clk); #1 cfg_start = 1'b0;
        wait_idle();
        verify_chain(2'b01, 16'h5A0F, "R6 ignored start");
    endtask

    task automatic t_powerdown();
        int lo = 0;
        int wk = 0;
        clear_mon();
        @(posedge clk); #1 pd_enter = 1'b1;
        @(posedge clk); #1 pd_enter = 1'b0;
        repeat (10) @(posedge clk);
        #1 pd_exit = 1'b1;
        @(posedge clk); #1 pd_exit = 1'b0;
        repeat (5) @(negedge clk);
        chk(!mem_ce2 && mem_ce1_n && busy, "R8", "early exit ignored", {mem_ce2, mem_ce1_n, busy}, 3'b011);
        repeat (DPDL) @(posedge clk);
        #1 cfg_start = 1'b1; cfg_sel = 2'b00;
        @(posedge clk); #1 cfg_start = 1'b0;
        repeat (10) @(negedge clk);
        chk(ncyc == 0 && lo_w == 0, "R8", "start while asleep", ncyc, 0);
        chk(cfg_shadow == 2'b10, "R8", "shadow kept while asleep", cfg_shadow, 2'b10);
        @(posedge clk); #1 pd_exit = 1'b1;
        @(posedge clk); #1 pd_exit = 1'b0;
        lo = busy_cnt;
        chk(lo >= DPDL + 1, "R8", "ce2 low width", lo, DPDL + 1);
        @(negedge clk);
        while (busy && wk < 100000) begin
            chk(mem_ce2 && mem_ce1_n, "R9", "wake pins", {mem_ce2, mem_ce1_n}, 2'b11);
            wk++;
            @(negedge clk);
        end
        chk(wk == WAKE, "R9", "wake length", wk, WAKE);
        chk(cfg_shadow == 2'b11, "R9", "shadow default after wake", cfg_shadow, 2'b11);
    endtask

    task automatic t_same_cycle();
        clear_mon();
        mem_pat = 16'hC001;
        @(posedge clk); #1 cfg_start = 1'b1; pd_enter = 1'b1; cfg_sel = 2'b00;
        @(posedge clk); #1 cfg_start = 1'b0; pd_enter = 1'b0;
        @(negedge clk);
        chk(mem_ce2 == 1'b1, "R10", "no sleep on collision", mem_ce2, 1);
        wait_idle();
        verify_chain(2'b00, 16'hC001, "R10 collision");
        chk(mem_ce2 == 1'b1, "R10", "ce2 high afterwards", mem_ce2, 1);
    endtask

    initial begin
        clear_mon();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_program(2'b00, 16'hA5C3);
        t_program(2'b01, 16'h1234);
        t_program(2'b10, 16'hFFFF);
        t_program(2'b11, 16'h0000);
        t_start_while_busy();
        t_program(2'b10, 16'h8E71);
        t_powerdown();
        t_program(2'b01, 16'h3C3C);
        t_same_cycle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule